// File: doc/BRIEF.md
# Serial-Read Switch Input Monitor with Change Interrupt

This block watches a bank of digital switch inputs and lets a host read their levels through a shift register clocked by a serial master. Every input passes through a synchroniser. A falling edge on the active-low chip select freezes the synchronised levels into a snapshot register and clears the pending interrupt. While chip select stays low, the serial clock walks the snapshot out on the serial data output, highest-numbered input first.

Whenever any input differs from the last snapshot, a sticky change flag is set. That flag drives an active-low, open-drain style interrupt, which an enable input can gate. Serial data in is shifted in behind the snapshot bits, so several monitors can be chained on one select line and read as one long word.

Chip select, serial clock and serial data in are all sampled by the system clock. Each phase of the serial clock must therefore last at least four system clocks.

Top module: `swmon_spi`

## Requirements
- R1: The input count is the parameter `NUM_IN`, and both 16 and 8 inputs work. A frame shifts exactly `NUM_IN` snapshot bits before the chained data begins.
- R2: On a falling edge of `cs_n`, the synchronised `sw_in` levels are copied into the snapshot and `irq_drive_low` returns to 0. Input changes made after that edge do not alter the bits read in the same frame.
- R3: While `cs_n` is low, the first rising `sclk` edge places snapshot bit `NUM_IN-1` on `sdo`. Each later rising edge moves to the next lower bit, so bit 0 comes out on rising edge `NUM_IN`.
- R4: `sdi` is sampled on each falling `sclk` edge. From rising edge `NUM_IN+1` onward, `sdo` repeats the sampled `sdi` bits in the order they arrived, which allows daisy-chaining.
- R5: When a synchronised input differs from the snapshot, a change flag is set and `irq_drive_low` becomes 1 while `int_en` is 1. The flag stays set even if the input returns to its snapshot level, and only the next `cs_n` falling edge clears it.
- R6: While `int_en` is 0, `irq_drive_low` is 0. A pending change is kept and appears once `int_en` returns to 1.
- R7: `sdo_oe` is 1 while the synchronised `cs_n` is low and 0 while it is high. The interrupt has only a drive-low enable and no path that drives high.
- R8: `sclk` edges while `cs_n` is high are ignored. The first rising edge of the next frame still loads the new snapshot.
- R9: After reset the snapshot is all zeros, the change flag is clear, and `sdo_oe` and `irq_drive_low` are 0.
- R10: Each `sclk` phase must last at least 4 system clocks. `sdo` carries its new bit by the third system clock edge after a rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_in | input | NUM_IN | Asynchronous switch levels |
| cs_n | input | 1 | Active-low chip select from the serial master |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, fed by the next device up the chain |
| int_en | input | 1 | Interrupt enable; 0 releases the interrupt line |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| irq_drive_low | output | 1 | 1 pulls the shared active-low interrupt line low |

## Verification
The bound checker watches, on every cycle, the cycle-level rules that tie internal events together:
- the snapshot copy and the flag clear on each select fall;
- the flag staying set until the next select fall, once any input has differed;
- the first-edge load and the one-bit walk of the shift register;
- the shift register holding still while select is high.

Only the bench's scenarios can show what depends on whole frames. This covers the order of bits on `sdo` for both widths, chained data appearing after the snapshot bits, the snapshot staying frozen against later input changes, the effect of the enable gating on the output pin, and serial clock activity outside a frame being harmless.

// File: rtl/swmon_pkg.sv
package swmon_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/swmon_sync.sv
module swmon_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swmon_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("swmon_sync: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/swmon_edge.sv
module swmon_edge
   import swmon_pkg::*;
#(
   parameter logic RST_LVL = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lvl,
   output edge_t ev
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= RST_LVL;
      end else begin
         prev <= lvl;
      end
   end

   assign ev.rise = lvl & ~prev;
   assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/swmon_chg.sv
module swmon_chg #(
   parameter int unsigned NUM_IN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] sw_s,
   input  logic              take,
   output logic [NUM_IN-1:0] snap,
   output logic              flag
);
   logic differs;

   assign differs = |(sw_s ^ snap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap <= '0;
         flag <= 1'b0;
      end else if (take) begin
         snap <= sw_s;
         flag <= 1'b0;
      end else begin
         flag <= flag | differs;
      end
   end
endmodule

// File: rtl/swmon_shift.sv
module swmon_shift #(
   parameter int unsigned NUM_IN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_on,
   input  logic              frame_start,
   input  logic              bit_rise,
   input  logic              bit_fall,
   input  logic              sdi_s,
   input  logic [NUM_IN-1:0] snap,
   output logic [NUM_IN-1:0] shreg,
   output logic              first,
   output logic              sdi_cap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         first   <= 1'b1;
         sdi_cap <= 1'b0;
      end else begin
         if (frame_start) begin
            first <= 1'b1;
         end else if (frame_on && bit_rise) begin
            first <= 1'b0;
            if (first) begin
               shreg <= snap;
            end else begin
               shreg <= {shreg[NUM_IN-2:0], sdi_cap};
            end
         end
         if (frame_on && bit_fall) begin
            sdi_cap <= sdi_s;
         end
      end
   end
endmodule

// File: rtl/swmon_spi.sv
module swmon_spi
   import swmon_pkg::*;
#(
   parameter int unsigned NUM_IN      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] sw_in,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              int_en,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              irq_drive_low
);
   localparam int unsigned CTL_W = 3;
   localparam logic [CTL_W-1:0] CTL_RST = 3'b100;

   generate
      if (NUM_IN < 2) begin : g_bad_num
         $error("swmon_spi: NUM_IN must be at least 2");
      end
   endgenerate

   logic [NUM_IN-1:0] sw_s;
   logic [NUM_IN-1:0] snap;
   logic [NUM_IN-1:0] shreg;
   logic [CTL_W-1:0]  ctl_s;
   logic              cs_high;
   logic              sclk_s;
   logic              sdi_s;
   logic              irq_flag;
   logic              first;
   logic              sdi_cap;
   edge_t             cs_ev;
   edge_t             sclk_ev;

   swmon_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
      .clk(clk), .rst_n(rst_n), .d(sw_in), .q(sw_s)
   );

   swmon_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(ctl_s)
   );

   assign cs_high = ctl_s[2];
   assign sclk_s  = ctl_s[1];
   assign sdi_s   = ctl_s[0];

   swmon_edge #(.RST_LVL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .lvl(cs_high), .ev(cs_ev)
   );

   swmon_edge #(.RST_LVL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .ev(sclk_ev)
   );

   swmon_chg #(.NUM_IN(NUM_IN)) u_chg (
      .clk(clk), .rst_n(rst_n), .sw_s(sw_s), .take(cs_ev.fall),
      .snap(snap), .flag(irq_flag)
   );

   swmon_shift #(.NUM_IN(NUM_IN)) u_shift (
      .clk(clk), .rst_n(rst_n), .frame_on(~cs_high), .frame_start(cs_ev.fall),
      .bit_rise(sclk_ev.rise), .bit_fall(sclk_ev.fall), .sdi_s(sdi_s),
      .snap(snap), .shreg(shreg), .first(first), .sdi_cap(sdi_cap)
   );

   assign sdo           = shreg[NUM_IN-1];
   assign sdo_oe        = ~cs_high;
   assign irq_drive_low = irq_flag & int_en;
endmodule

// File: rtl/swmon_chk.sv
module swmon_chk
   import swmon_pkg::*;
#(
   parameter int unsigned NUM_IN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_IN-1:0] sw_s,
   input logic [NUM_IN-1:0] snap,
   input logic [NUM_IN-1:0] shreg,
   input logic              irq_flag,
   input logic              cs_high,
   input edge_t             cs_ev,
   input edge_t             sclk_ev,
   input logic              first,
   input logic              sdi_cap
);
   // R2: the snapshot takes the synchronised levels on select fall
   a_r2_snapshot_take: assert property (@(posedge clk) disable iff (!rst_n)
      cs_ev.fall |=> snap == $past(sw_s));

   // R2: the change flag is clear right after a select fall
   a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cs_ev.fall |=> !irq_flag);

   // R5: a difference outside a select fall sets the flag
   a_r5_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_s != snap) && !cs_ev.fall) |=> irq_flag);

   // R5: the flag is sticky until the next select fall
   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !cs_ev.fall) |=> irq_flag);

   // R3: the first rising edge in a frame loads the snapshot
   a_r3_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_ev.rise && !cs_high && first && !cs_ev.fall) |=> shreg == $past(snap));

   // R3 / R4: later rising edges move one bit and take the sampled input
   a_r4_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_ev.rise && !cs_high && !first && !cs_ev.fall)
      |=> (shreg[NUM_IN-1:1] == $past(shreg[NUM_IN-2:0])) && (shreg[0] == $past(sdi_cap)));

   // R8: nothing shifts while select is high or just after it rises
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_high || cs_ev.rise) |=> $stable(shreg));
endmodule

bind swmon_spi swmon_chk #(.NUM_IN(NUM_IN)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_s(sw_s), .snap(snap), .shreg(shreg),
   .irq_flag(irq_flag), .cs_high(cs_high), .cs_ev(cs_ev), .sclk_ev(sclk_ev),
   .first(first), .sdi_cap(sdi_cap)
);

// File: tb/sim_swmon_spi.sv
`timescale 1ns/1ps
module sim_swmon_spi;
   localparam int PH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sw0 = '0;
   logic [7:0]  sw1 = '0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        int_en = 1'b1;
   logic        sdo0, oe0, irq0;
   logic        sdo1, oe1, irq1;
   logic [63:0] got0, got1;
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   swmon_spi #(.NUM_IN(16)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_in(sw0), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .int_en(int_en), .sdo(sdo0), .sdo_oe(oe0), .irq_drive_low(irq0)
   );

   swmon_spi #(.NUM_IN(8)) u1 (
      .clk(clk), .rst_n(rst_n), .sw_in(sw1), .cs_n(cs_n), .sclk(sclk), .sdi(sdo0),
      .int_en(int_en), .sdo(sdo1), .sdo_oe(oe1), .irq_drive_low(irq1)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_clk(PH);
   endtask

   task automatic desel();
      cs_n = 1'b1;
      wait_clk(PH);
   endtask

   task automatic xfer(input int n, input logic [31:0] din);
      for (int i = 0; i < n; i++) begin
         sdi  = din[31-i];
         sclk = 1'b1;
         wait_clk(3);
         got0 = {got0[62:0], sdo0};
         got1 = {got1[62:0], sdo1};
         wait_clk(PH - 3);
         sclk = 1'b0;
         wait_clk(PH);
      end
   endtask

   task automatic t_reset();
      check("R9 irq after reset", {31'd0, irq0}, 32'd0);
      check("R9 oe after reset", {31'd0, oe0}, 32'd0);
      check("R7 oe idle select high", {31'd0, oe1}, 32'd0);
   endtask

   task automatic t_change_irq();
      sw0 = 16'h0001;
      wait_clk(4);
      check("R5 irq on change", {31'd0, irq0}, 32'd1);
      sw0 = 16'h0000;
      wait_clk(4);
      check("R5 irq sticky after return", {31'd0, irq0}, 32'd1);
      check("R5 other device quiet", {31'd0, irq1}, 32'd0);
   endtask

   task automatic t_int_en();
      int_en = 1'b0;
      wait_clk(1);
      check("R6 disabled releases line", {31'd0, irq0}, 32'd0);
      int_en = 1'b1;
      wait_clk(1);
      check("R6 pending kept", {31'd0, irq0}, 32'd1);
   endtask

   task automatic t_chain();
      sw0 = 16'hA5C3;
      sw1 = 8'h3C;
      wait_clk(PH);
      check("R5 chained device raises", {31'd0, irq1}, 32'd1);
      sel();
      check("R2 clear on select u0", {31'd0, irq0}, 32'd0);
      check("R2 clear on select u1", {31'd0, irq1}, 32'd0);
      check("R7 oe in frame", {31'd0, oe0}, 32'd1);
      got0 = '0;
      got1 = '0;
      xfer(32, 32'hBEEF_1234);
      check("R3 R10 u0 msb-first snapshot", {16'd0, got0[31:16]}, 32'h0000_A5C3);
      check("R4 u0 passes sdi bits", {16'd0, got0[15:0]}, 32'h0000_BEEF);
      check("R1 R4 8-bit device then chain", got1[31:0], 32'h3CA5_C3BE);
      desel();
      check("R7 oe after frame", {31'd0, oe0}, 32'd0);
   endtask

   task automatic t_snapshot_hold();
      sel();
      sw0 = 16'hFFFF;
      wait_clk(PH);
      check("R5 change during frame", {31'd0, irq0}, 32'd1);
      got0 = '0;
      xfer(16, 32'd0);
      check("R2 frame reads frozen snapshot", {16'd0, got0[15:0]}, 32'h0000_A5C3);
      desel();
      sel();
      check("R2 next select clears", {31'd0, irq0}, 32'd0);
      got0 = '0;
      xfer(16, 32'd0);
      check("R2 new snapshot read", {16'd0, got0[15:0]}, 32'h0000_FFFF);
      desel();
   endtask

   task automatic t_idle_sclk();
      sw0 = 16'h1234;
      wait_clk(PH);
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1;
         wait_clk(PH);
         sclk = 1'b0;
         wait_clk(PH);
      end
      check("R7 oe stays off with idle clocks", {31'd0, oe0}, 32'd0);
      sel();
      got0 = '0;
      xfer(16, 32'd0);
      check("R8 first edge still loads snapshot", {16'd0, got0[15:0]}, 32'h0000_1234);
      desel();
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_change_irq();
      t_int_en();
      t_chain();
      t_snapshot_hold();
      t_idle_sclk();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule